// File: doc/BRIEF.md
# LCD Timing Signal Output Stage

This block sits between a display controller's timing generator and the pins of a panel. It takes a line-start event, a frame-start event, a pixel data-valid strobe and a 24-bit pixel bus. From these it produces the panel clock, horizontal sync, vertical sync, line-load strobe, a frame-toggle signal and the segment data bus. The counters that set line and frame lengths live upstream and arrive here only as single-cycle events.

The configuration inputs decide how each output is shaped. They cover clock gating to valid-data periods, with an override for passive-matrix panels. They also set the line-load pulse length or gating, a per-output polarity, the vertical sync width in whole line periods, blanking of the data bus, and the source and rate of the frame-toggle pin. The start/stop input is live. Every other setting is captured at a frame-start event, or tracked continuously while the block is stopped, so that no setting can change part-way through a frame.

All outputs are registered once behind the events. An output changes in the first cycle after the rising clock edge that samples the event causing the change.

Top module: `lcd_out_stage`

## Requirements
- R1: While `run_i` is 0, `ld_o` is 0, the panel clock does not toggle, and HSYNC, VSYNC and LOAD sit at their inactive levels, whatever the event and data inputs do.
- R2: With `cfg_clk_gate_i`=0 and `cfg_stn_i`=0, the internal panel clock toggles on every cycle, so a window of 16 cycles holds exactly 8 rising edges of `pclk_o`.
- R3: With `cfg_clk_gate_i`=1, or with `cfg_stn_i`=1 whatever the gate bit is, the internal panel clock toggles only in cycles where `valid_i` was 1 and otherwise returns to 0. A run of V valid cycles therefore gives ceil(V/2) active edges.
- R4: With `cfg_load_gate_i`=0, a line-start event asserts LOAD for `cfg_load_len_i` cycles, where a value of 0 gives 1 cycle. With `cfg_load_gate_i`=1, LOAD is asserted exactly in the cycles after `valid_i` was 1, and line-start has no effect on it.
- R5: Each polarity bit (`cfg_pol_clk_i`, `cfg_pol_hs_i`, `cfg_pol_vs_i`, `cfg_pol_ld_i`) inverts its output when 1. When it is 0, the output is active high and idles at 0.
- R6: A frame-start event (issued together with a line-start) asserts VSYNC. VSYNC stays active for N line periods, with N=1, 2 or 3 for `cfg_vs_width_i` = 00, 01 or 10. The value 11 gives N=1.
- R7: With `cfg_blank_i`=1, `ld_o` is all zeros. With `cfg_blank_i`=0, `ld_o` equals the `pix_i` value of the previous cycle when `valid_i` was 1, and 0 otherwise.
- R8: With `cfg_fr_sel_i`=1, `frame_o` follows `pclk_o`. With `cfg_fr_sel_i`=0, `frame_o` carries the toggle signal.
- R9: With `cfg_fr_div_i`=0, the toggle signal inverts at each line-start. With `cfg_fr_div_i`=1, it inverts only at frame-start, and line-starts leave it unchanged.
- R10: All settings except `run_i` take effect at the frame-start event, or at once while `run_i` is 0. A change in the middle of a frame does not alter any output until the next frame-start.
- R11: Each line-start event gives one HSYNC pulse, exactly one cycle wide, in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Start (1) / stop (0) |
| valid_i | input | 1 | Pixel data valid strobe |
| line_start_i | input | 1 | Single-cycle line-start event |
| frame_start_i | input | 1 | Single-cycle frame-start event |
| pix_i | input | DATA_W | Pixel data |
| cfg_clk_gate_i | input | 1 | 1: panel clock only during valid data |
| cfg_stn_i | input | 1 | Passive-matrix mode, forces clock gating |
| cfg_load_gate_i | input | 1 | 1: LOAD follows valid data |
| cfg_pol_clk_i | input | 1 | Panel clock invert |
| cfg_pol_hs_i | input | 1 | HSYNC invert |
| cfg_pol_vs_i | input | 1 | VSYNC invert |
| cfg_pol_ld_i | input | 1 | LOAD invert |
| cfg_vs_width_i | input | 2 | VSYNC width in line periods (11 acts as 00) |
| cfg_blank_i | input | 1 | Force data bus to zero |
| cfg_fr_sel_i | input | 1 | Frame pin source: 0 toggle, 1 panel clock |
| cfg_fr_div_i | input | 1 | 1: toggle per frame instead of per line |
| cfg_load_len_i | input | LEN_W | Programmed LOAD width in cycles (0 acts as 1) |
| pclk_o | output | 1 | Panel clock |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| load_o | output | 1 | Line-load strobe |
| frame_o | output | 1 | Frame-toggle pin |
| ld_o | output | DATA_W | Segment data |

## Verification
A wrong remaining-lines count in the VSYNC generator shows up as a VSYNC pulse that covers the wrong number of HSYNC pulses, and it becomes visible within one frame's first three lines. A panel-clock flop that is stuck, or gated the wrong way, changes the count of rising edges in a single 16-cycle window. A stale or early-loaded settings register shows as a wrong idle level on HSYNC in the very cycle after a mid-frame change or a frame-start. A LOAD countdown that is off by one changes the number of cycles LOAD is high after the next line-start.

// File: rtl/lcd_out_pkg.sv
package lcd_out_pkg;

    localparam int LCD_LEN_W = 4;
    localparam int LCD_VSW_W = 2;

    typedef struct packed {
        logic                 clk_gate;
        logic                 stn;
        logic                 load_gate;
        logic                 pol_clk;
        logic                 pol_hs;
        logic                 pol_vs;
        logic                 pol_ld;
        logic [LCD_VSW_W-1:0] vs_width;
        logic                 blank;
        logic                 fr_sel;
        logic                 fr_div;
        logic [LCD_LEN_W-1:0] load_len;
    } lcd_cfg_t;

    localparam lcd_cfg_t LCD_CFG_RESET = '0;

endpackage

// File: rtl/lcd_cfg_shadow.sv
module lcd_cfg_shadow
    import lcd_out_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run_i,
    input  logic     frame_start_i,
    input  lcd_cfg_t cfg_i,
    output lcd_cfg_t cfg_eff_o,
    output lcd_cfg_t cfg_q_o
);

    lcd_cfg_t shadow_d, shadow_q;

    always_comb begin
        if (!run_i || frame_start_i) begin
            cfg_eff_o = cfg_i;
        end else begin
            cfg_eff_o = shadow_q;
        end
        shadow_d = cfg_eff_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= LCD_CFG_RESET;
        end else begin
            shadow_q <= shadow_d;
        end
    end

    assign cfg_q_o = shadow_q;

    AST_CFG_HOLD_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !frame_start_i) |=> $stable(shadow_q)); // R10

endmodule

// File: rtl/lcd_pclk_gen.sv
module lcd_pclk_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic valid_i,
    input  logic gate_only_i,
    output logic raw_o
);

    typedef struct packed {
        logic raw;
    } pclk_st_t;

    pclk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run_i && (!gate_only_i || valid_i)) begin
            st_d.raw = ~st_q.raw;
        end else begin
            st_d.raw = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_o = st_q.raw;

    AST_PCLK_GATED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && gate_only_i && !valid_i) |=> !raw_o); // R3
    AST_PCLK_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !gate_only_i) |=> (raw_o != $past(raw_o))); // R2
    AST_PCLK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !raw_o); // R1

endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen #(
    parameter int VSW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             line_start_i,
    input  logic             frame_start_i,
    input  logic [VSW_W-1:0] vs_width_i,
    output logic             hs_o,
    output logic             vs_o
);

    localparam logic [VSW_W-1:0] VSW_RSVD = '1;
    localparam int               CNT_W    = VSW_W;

    typedef struct packed {
        logic             hs;
        logic             vs;
        logic [CNT_W-1:0] left;
    } sync_st_t;

    sync_st_t         st_d, st_q;
    logic [CNT_W-1:0] lines_n;

    always_comb begin
        if (vs_width_i == VSW_RSVD) begin
            lines_n = CNT_W'(1);
        end else begin
            lines_n = vs_width_i + CNT_W'(1);
        end

        st_d = st_q;
        if (!run_i) begin
            st_d = '0;
        end else begin
            st_d.hs = line_start_i;
            if (frame_start_i) begin
                st_d.vs   = 1'b1;
                st_d.left = lines_n;
            end else if (line_start_i && st_q.vs) begin
                if (st_q.left <= CNT_W'(1)) begin
                    st_d.vs   = 1'b0;
                    st_d.left = '0;
                end else begin
                    st_d.left = st_q.left - CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hs_o = st_q.hs;
    assign vs_o = st_q.vs;

    AST_VS_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.vs |-> (st_q.left == '0)); // R6
    AST_HS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hs |-> $past(line_start_i)); // R11
    AST_VS_NEVER_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vs |-> (st_q.left != '0)); // R6

endmodule

// File: rtl/lcd_load_gen.sv
module lcd_load_gen #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             valid_i,
    input  logic             line_start_i,
    input  logic             gate_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             load_o
);

    typedef struct packed {
        logic             load;
        logic [LEN_W-1:0] left;
    } load_st_t;

    load_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run_i) begin
            st_d = '0;
        end else if (gate_i) begin
            st_d.load = valid_i;
            st_d.left = '0;
        end else if (line_start_i) begin
            st_d.load = 1'b1;
            st_d.left = (len_i == '0) ? '0 : len_i - LEN_W'(1);
        end else if (st_q.left != '0) begin
            st_d.load = 1'b1;
            st_d.left = st_q.left - LEN_W'(1);
        end else begin
            st_d.load = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_o = st_q.load;

    AST_LOAD_COUNT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.left != '0) |-> st_q.load); // R4
    AST_LOAD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !st_q.load); // R1

endmodule

// File: rtl/lcd_out_stage.sv
module lcd_out_stage
    import lcd_out_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int LEN_W  = lcd_out_pkg::LCD_LEN_W,
    parameter int VSW_W  = lcd_out_pkg::LCD_VSW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              valid_i,
    input  logic              line_start_i,
    input  logic              frame_start_i,
    input  logic [DATA_W-1:0] pix_i,
    input  logic              cfg_clk_gate_i,
    input  logic              cfg_stn_i,
    input  logic              cfg_load_gate_i,
    input  logic              cfg_pol_clk_i,
    input  logic              cfg_pol_hs_i,
    input  logic              cfg_pol_vs_i,
    input  logic              cfg_pol_ld_i,
    input  logic [VSW_W-1:0]  cfg_vs_width_i,
    input  logic              cfg_blank_i,
    input  logic              cfg_fr_sel_i,
    input  logic              cfg_fr_div_i,
    input  logic [LEN_W-1:0]  cfg_load_len_i,
    output logic              pclk_o,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              load_o,
    output logic              frame_o,
    output logic [DATA_W-1:0] ld_o
);

    typedef struct packed {
        logic              tog;
        logic [DATA_W-1:0] ld;
    } top_st_t;

    lcd_cfg_t cfg_in, cfg_eff, cfg_q;
    top_st_t  st_d, st_q;
    logic     pclk_raw, hs_raw, vs_raw, load_raw;
    logic     gate_only;

    always_comb begin
        cfg_in           = LCD_CFG_RESET;
        cfg_in.clk_gate  = cfg_clk_gate_i;
        cfg_in.stn       = cfg_stn_i;
        cfg_in.load_gate = cfg_load_gate_i;
        cfg_in.pol_clk   = cfg_pol_clk_i;
        cfg_in.pol_hs    = cfg_pol_hs_i;
        cfg_in.pol_vs    = cfg_pol_vs_i;
        cfg_in.pol_ld    = cfg_pol_ld_i;
        cfg_in.vs_width  = cfg_vs_width_i;
        cfg_in.blank     = cfg_blank_i;
        cfg_in.fr_sel    = cfg_fr_sel_i;
        cfg_in.fr_div    = cfg_fr_div_i;
        cfg_in.load_len  = cfg_load_len_i;
    end

    lcd_cfg_shadow u_shadow (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_i         (run_i),
        .frame_start_i (frame_start_i),
        .cfg_i         (cfg_in),
        .cfg_eff_o     (cfg_eff),
        .cfg_q_o       (cfg_q)
    );

    assign gate_only = cfg_eff.clk_gate | cfg_eff.stn;

    lcd_pclk_gen u_pclk (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run_i),
        .valid_i     (valid_i),
        .gate_only_i (gate_only),
        .raw_o       (pclk_raw)
    );

    lcd_sync_gen #(.VSW_W(VSW_W)) u_sync (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_i         (run_i),
        .line_start_i  (line_start_i),
        .frame_start_i (frame_start_i),
        .vs_width_i    (cfg_eff.vs_width),
        .hs_o          (hs_raw),
        .vs_o          (vs_raw)
    );

    lcd_load_gen #(.LEN_W(LEN_W)) u_load (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run_i),
        .valid_i      (valid_i),
        .line_start_i (line_start_i),
        .gate_i       (cfg_eff.load_gate),
        .len_i        (cfg_eff.load_len),
        .load_o       (load_raw)
    );

    always_comb begin
        st_d = st_q;
        if (!run_i) begin
            st_d = '0;
        end else begin
            if (cfg_eff.fr_div ? frame_start_i : line_start_i) begin
                st_d.tog = ~st_q.tog;
            end
            st_d.ld = (valid_i && !cfg_eff.blank) ? pix_i : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pclk_o  = pclk_raw ^ cfg_q.pol_clk;
    assign hsync_o = hs_raw   ^ cfg_q.pol_hs;
    assign vsync_o = vs_raw   ^ cfg_q.pol_vs;
    assign load_o  = load_raw ^ cfg_q.pol_ld;
    assign frame_o = cfg_q.fr_sel ? pclk_o : st_q.tog;
    assign ld_o    = st_q.ld;

    AST_STOP_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (ld_o == '0)); // R1
    AST_BLANK_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && cfg_eff.blank) |=> (ld_o == '0)); // R7
    AST_TOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !line_start_i && !frame_start_i) |=> $stable(st_q.tog)); // R9
    AST_HS_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !line_start_i) |=> (hsync_o == cfg_q.pol_hs)); // R5

endmodule

// File: tb/lcd_out_stage_tb_top.sv
module lcd_out_stage_tb_top;

    localparam int DATA_W = 24;
    localparam int LEN_W  = 4;
    localparam int WIN    = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              run_i = 1'b0, valid_i = 1'b0, line_start_i = 1'b0, frame_start_i = 1'b0;
    logic [DATA_W-1:0] pix_i = '0;
    logic              cfg_clk_gate_i = 0, cfg_stn_i = 0, cfg_load_gate_i = 0;
    logic              cfg_pol_clk_i = 0, cfg_pol_hs_i = 0, cfg_pol_vs_i = 0, cfg_pol_ld_i = 0;
    logic [1:0]        cfg_vs_width_i = 2'b00;
    logic              cfg_blank_i = 0, cfg_fr_sel_i = 0, cfg_fr_div_i = 0;
    logic [LEN_W-1:0]  cfg_load_len_i = '0;
    logic              pclk_o, hsync_o, vsync_o, load_o, frame_o;
    logic [DATA_W-1:0] ld_o;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    lcd_out_stage #(.DATA_W(DATA_W), .LEN_W(LEN_W), .VSW_W(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .valid_i(valid_i),
        .line_start_i(line_start_i), .frame_start_i(frame_start_i), .pix_i(pix_i),
        .cfg_clk_gate_i(cfg_clk_gate_i), .cfg_stn_i(cfg_stn_i), .cfg_load_gate_i(cfg_load_gate_i),
        .cfg_pol_clk_i(cfg_pol_clk_i), .cfg_pol_hs_i(cfg_pol_hs_i), .cfg_pol_vs_i(cfg_pol_vs_i),
        .cfg_pol_ld_i(cfg_pol_ld_i), .cfg_vs_width_i(cfg_vs_width_i), .cfg_blank_i(cfg_blank_i),
        .cfg_fr_sel_i(cfg_fr_sel_i), .cfg_fr_div_i(cfg_fr_div_i), .cfg_load_len_i(cfg_load_len_i),
        .pclk_o(pclk_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .load_o(load_o),
        .frame_o(frame_o), .ld_o(ld_o)
    );

    // clk_gate, stn, pol, valid cycles, expected rising edges of pclk_o in WIN cycles
    typedef struct packed {
        logic   gate;
        logic   stn;
        logic   pol;
        int     nval;
        int     rises;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b0, 1'b0, 5, 8},
        '{1'b1, 1'b0, 1'b0, 5, 3},
        '{1'b1, 1'b0, 1'b0, 6, 3},
        '{1'b0, 1'b1, 1'b0, 5, 3},
        '{1'b1, 1'b1, 1'b0, 4, 2},
        '{1'b0, 1'b0, 1'b1, 7, 8},
        '{1'b1, 1'b0, 1'b1, 7, 4},
        '{1'b1, 1'b0, 1'b0, 1, 1}
    };

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive inputs (caller is at a falling edge), then wait to the next falling edge
    task automatic step(input bit fs, input bit ls, input bit v, input logic [DATA_W-1:0] px);
        frame_start_i = fs;
        line_start_i  = ls;
        valid_i       = v;
        pix_i         = px;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, '0);
    endtask

    task automatic vs_measure(input logic [1:0] w, input logic pol, input int exp);
        int hs_in_vs;
        cfg_vs_width_i = w;
        cfg_pol_vs_i   = pol;
        idle(2);
        step(1, 1, 0, '0);
        hs_in_vs = 0;
        if (hsync_o && (vsync_o != pol)) hs_in_vs++;
        for (int ln = 0; ln < 6; ln++) begin
            step(0, 1, 0, '0);
            if (hsync_o && (vsync_o != pol)) hs_in_vs++;
            for (int k = 0; k < 3; k++) begin
                step(0, 0, 0, '0);
                if (hsync_o && (vsync_o != pol)) hs_in_vs++;
            end
        end
        chk(hs_in_vs == exp, $sformatf("R6 width field %0b", w), hs_in_vs, exp);
    endtask

    task automatic load_measure(input bit gate, input logic [LEN_W-1:0] len, input int nval, input int exp);
        int hi;
        cfg_load_gate_i = gate;
        cfg_load_len_i  = len;
        idle(20);
        step(1, 1, 0, '0);
        hi = load_o ? 1 : 0;
        for (int i = 1; i < 20; i++) begin
            step(0, 0, (i <= nval), '0);
            if (load_o) hi++;
        end
        chk(hi == exp, $sformatf("R4 load gate=%0b len=%0d", gate, len), hi, exp);
    endtask

    initial begin
        int rises;
        logic prev, a, b;
        int mism;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({pclk_o, hsync_o, vsync_o, load_o, frame_o} == 5'b0, "R1 reset idle",
            {pclk_o, hsync_o, vsync_o, load_o, frame_o}, 0);
        chk(ld_o == '0, "R1 reset data", ld_o, 0);

        // R1: stopped block ignores events and data
        mism = 0;
        prev = pclk_o;
        for (int i = 0; i < 6; i++) begin
            step(i == 0, 1, 1, 24'hFFFFFF);
            if (hsync_o || vsync_o || load_o || ld_o != '0 || pclk_o != prev) mism++;
        end
        chk(mism == 0, "R1 stopped outputs", mism, 0);

        run_i = 1'b1;
        idle(2);

        // R2 R3 R5: panel clock edge counts per line, walked from the vector table
        foreach (VECS[n]) begin
            cfg_clk_gate_i = VECS[n].gate;
            cfg_stn_i      = VECS[n].stn;
            cfg_pol_clk_i  = VECS[n].pol;
            step(1, 1, 0, '0);
            prev  = pclk_o;
            rises = 0;
            for (int i = 1; i <= WIN; i++) begin
                step(0, 0, (i <= VECS[n].nval), '0);
                if (!prev && pclk_o) rises++;
                prev = pclk_o;
            end
            chk(rises == VECS[n].rises,
                $sformatf("R2/R3/R5 vec %0d gate=%0b stn=%0b", n, VECS[n].gate, VECS[n].stn),
                rises, VECS[n].rises);
        end
        cfg_clk_gate_i = 0; cfg_stn_i = 0; cfg_pol_clk_i = 0;

        // R6: VSYNC width in line periods
        vs_measure(2'b00, 1'b0, 1);
        vs_measure(2'b01, 1'b0, 2);
        vs_measure(2'b10, 1'b0, 3);
        vs_measure(2'b11, 1'b0, 1);
        vs_measure(2'b01, 1'b1, 2);   // R5 inverted VSYNC
        chk(vsync_o == 1'b1, "R5 vsync inverted idle", vsync_o, 1);
        cfg_pol_vs_i = 0;

        // R4: LOAD width and gating
        load_measure(1'b0, 4'd3, 0, 3);
        load_measure(1'b0, 4'd0, 0, 1);
        load_measure(1'b0, 4'd15, 0, 15);
        load_measure(1'b1, 4'd9, 5, 5);
        cfg_pol_ld_i = 1'b1;
        load_measure(1'b0, 4'd4, 0, 16);   // R5 inverted LOAD: 20 samples, 4 active-low
        cfg_pol_ld_i = 1'b0;
        cfg_load_gate_i = 1'b0;
        idle(20);

        // R11: HSYNC one cycle after line start, one cycle wide
        step(0, 1, 0, '0);
        a = hsync_o;
        step(0, 0, 0, '0);
        chk(a == 1'b1 && hsync_o == 1'b0, "R11 hsync pulse", {a, hsync_o}, 2'b10);

        // R7: data pass and blanking
        step(1, 1, 0, '0);
        step(0, 0, 1, 24'hA5C3F0);
        chk(ld_o == 24'hA5C3F0, "R7 data pass", ld_o, 24'hA5C3F0);
        step(0, 0, 0, 24'h123456);
        chk(ld_o == '0, "R7 no valid", ld_o, 0);
        cfg_blank_i = 1'b1;
        step(1, 1, 0, '0);
        step(0, 0, 1, 24'h5A5A5A);
        chk(ld_o == '0, "R7 blanked", ld_o, 0);
        cfg_blank_i = 1'b0;

        // R9: toggle per line / per frame
        cfg_fr_sel_i = 0; cfg_fr_div_i = 0;
        step(1, 1, 0, '0);
        a = frame_o;
        step(0, 1, 0, '0);
        chk(frame_o != a, "R9 per-line toggle", frame_o, ~a);
        cfg_fr_div_i = 1;
        step(1, 1, 0, '0);
        a = frame_o;
        step(0, 1, 0, '0); step(0, 1, 0, '0); step(0, 1, 0, '0);
        chk(frame_o == a, "R9 lines ignored in frame mode", frame_o, a);
        step(1, 1, 0, '0);
        chk(frame_o != a, "R9 per-frame toggle", frame_o, ~a);
        cfg_fr_div_i = 0;

        // R8: frame pin carries the panel clock
        cfg_fr_sel_i = 1;
        step(1, 1, 0, '0);
        mism = 0;
        for (int i = 0; i < 8; i++) begin
            step(0, 0, 0, '0);
            if (frame_o != pclk_o) mism++;
        end
        chk(mism == 0, "R8 frame follows pclk", mism, 0);
        cfg_fr_sel_i = 0;

        // R10: mid-frame polarity change held until frame start
        cfg_pol_hs_i = 0;
        step(1, 1, 0, '0);
        idle(2);
        cfg_pol_hs_i = 1;
        idle(3);
        chk(hsync_o == 1'b0, "R10 mid-frame change held", hsync_o, 0);
        step(1, 1, 0, '0);
        b = hsync_o;
        step(0, 0, 0, '0);
        chk(b == 1'b0 && hsync_o == 1'b1, "R10/R5 new polarity after frame start",
            {b, hsync_o}, 2'b01);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule